// File: doc/BRIEF.md
# Autoreload Timer With Clock Prescale

This block is a classic microcontroller timer/counter built from two 8-bit count registers, a low half and a high half. A two-bit mode field turns the pair into a 13-bit counter (five low bits acting as a prescaler), a 16-bit counter, an 8-bit counter that reloads its low half from the high half on every wrap, or a frozen counter that keeps its value. In the reload mode the timer is the usual baud-rate source for an asynchronous serial port. Each wrap produces a one-cycle strobe that a downstream serial divider can consume directly.

The increment source is either an internal prescaler or an external count pin. The prescaler divides the single system clock by 12, by 4 or by 1, picked by a slow/medium select bit and a high-speed override. Counting is enabled by a run bit and can also be qualified by an external gate pin. Both external pins pass through a two-flop synchronizer. The count pin feeds a two-state edge tracker with the states PIN_LOW and PIN_HIGH. The tracker moves PIN_LOW to PIN_HIGH when the synchronized pin reads 1, and PIN_HIGH to PIN_LOW when it reads 0. It reports a falling edge while it sits in PIN_HIGH and the pin reads 0. The tracker resets into PIN_LOW, so a pin that is low at reset produces no edge. The core names its modes MODE_SPLIT13 (00), MODE_WIDE16 (01), MODE_RELOAD8 (10) and MODE_HALT (11).

Top module: `autoreload_timer`

## Requirements
- R1: After reset, both count halves are 0x00 and the overflow flag, the overflow strobe and the interrupt output are all 0.
- R2: The prescaler issues one increment opportunity every system clock when the high-speed select is 1, and then ignores the divide-by-4 select. With the high-speed select at 0, it issues one every 4 clocks when the divide-by-4 select is 1 and one every 12 clocks when it is 0.
- R3: The timer increments only while run is 1. When the gate enable is 1, the gate pin must also read high after two synchronizer flops.
- R4: When the counter select is 1, the prescaler is ignored and the timer increments once for each falling edge of the count pin, seen after two synchronizer flops.
- R5: Mode 00 counts a 13-bit value whose low 5 bits sit in the low half and whose upper 8 bits are the high half. Bits 7:5 of the low half are left untouched. The value wraps from high=0xFF, low[4:0]=0x1F to zero.
- R6: Mode 01 counts {high, low} as a 16-bit value and wraps from 0xFFFF to 0x0000.
- R7: Mode 10 increments the low half only. When it would pass 0xFF, it is loaded instead from the high half, and the high half is left unchanged.
- R8: Mode 11 holds both halves whatever the run, gate and clock settings are.
- R9: Every wrap raises the overflow strobe for exactly the clock in which the wrapped count appears, and sets the overflow flag in that same clock. The interrupt output is 1 exactly when the flag and the interrupt enable are both 1.
- R10: A flag-clear pulse clears the overflow flag on the next clock, unless a wrap happens in that same clock, in which case the flag stays set.
- R11: A write strobe for the low or high half loads that half from the write data on the next clock, and no increment happens in that clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Run enable |
| gate_en | input | 1 | 1: counting also needs the gate pin to be high |
| ext_count_sel | input | 1 | 1: count falling edges of count_pin |
| fast_clk_sel | input | 1 | 1: prescaler divides by 1 |
| div4_sel | input | 1 | With fast_clk_sel at 0: 1 divides by 4, 0 divides by 12 |
| mode | input | 2 | 00 split 13-bit, 01 16-bit, 10 8-bit reload, 11 halt |
| gate_pin | input | 1 | Asynchronous gate pin |
| count_pin | input | 1 | Asynchronous external count pin |
| wr_lo | input | 1 | Load the low half from wr_data |
| wr_hi | input | 1 | Load the high half from wr_data |
| wr_data | input | 8 | Load value |
| flag_clr | input | 1 | Clear the overflow flag |
| irq_en | input | 1 | Interrupt enable |
| count_lo | output | 8 | Low half of the count |
| count_hi | output | 8 | High half of the count |
| ovf_flag | output | 1 | Sticky overflow flag |
| ovf_tick | output | 1 | One-clock strobe on every wrap |
| irq | output | 1 | Overflow interrupt request |

## Verification
The assertions check these properties on every clock: a halted or stopped timer holds its count, the strobe always comes with the flag, a reload-mode wrap leaves the low half equal to the high half, a clear without a wrap leaves the flag at 0, and the interrupt never fires without the flag. The exact prescale spacing, the 13-bit carry and the untouched upper bits of the low half, edge counting through the synchronizer, and the gate qualification are shown only by the bench. The bench drives these scenarios against its behavioural model clock by clock.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic [1:0] {
        MODE_SPLIT13 = 2'b00,
        MODE_WIDE16  = 2'b01,
        MODE_RELOAD8 = 2'b10,
        MODE_HALT    = 2'b11
    } tmr_mode_e;

    typedef enum logic {
        PIN_LOW  = 1'b0,
        PIN_HIGH = 1'b1
    } pin_state_e;

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int SLOW_DIV = 12,
    parameter int MID_DIV  = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fast_sel,
    input  logic mid_sel,
    output logic tick
);
    localparam int PW = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;

    logic [PW-1:0] div_cnt;
    logic [PW-1:0] limit;

    // The high-speed select overrides the divide-by-4 select.
    always_comb begin
        if (fast_sel)
            limit = '0;
        else if (mid_sel)
            limit = PW'(MID_DIV - 1);
        else
            limit = PW'(SLOW_DIV - 1);
        tick = (div_cnt >= limit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            div_cnt <= '0;
        else if (tick)
            div_cnt <= '0;
        else
            div_cnt <= div_cnt + 1'b1;
    end
endmodule

// File: rtl/tmr_pin_sync.sv
module tmr_pin_sync
    import tmr_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic gate_raw,
    input  logic count_raw,
    output logic gate_sync,
    output logic fall_pulse
);
    logic [STAGES-1:0] gate_sh;
    logic [STAGES-1:0] cnt_sh;
    logic              cnt_sync;
    pin_state_e        state_q;
    pin_state_e        state_d;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    gate_sh[i] <= 1'b0;
                    cnt_sh[i]  <= 1'b0;
                end else begin
                    gate_sh[i] <= gate_raw;
                    cnt_sh[i]  <= count_raw;
                end
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    gate_sh[i] <= 1'b0;
                    cnt_sh[i]  <= 1'b0;
                end else begin
                    gate_sh[i] <= gate_sh[i-1];
                    cnt_sh[i]  <= cnt_sh[i-1];
                end
            end
        end
    end

    assign gate_sync = gate_sh[STAGES-1];
    assign cnt_sync  = cnt_sh[STAGES-1];

    // Edge tracker: state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= PIN_LOW;
        else
            state_q <= state_d;
    end

    // Edge tracker: transitions and output
    always_comb begin
        state_d    = state_q;
        fall_pulse = 1'b0;
        unique case (state_q)
            PIN_LOW: begin
                if (cnt_sync)
                    state_d = PIN_HIGH;
            end
            PIN_HIGH: begin
                if (!cnt_sync) begin
                    state_d    = PIN_LOW;
                    fall_pulse = 1'b1;
                end
            end
        endcase
    end
endmodule

// File: rtl/tmr_core.sv
module tmr_core
    import tmr_pkg::*;
#(
    parameter int CNT_W   = 8,
    parameter int PRESC_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic [1:0]       mode,
    input  logic             wr_lo,
    input  logic             wr_hi,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             flag_clr,
    output logic [CNT_W-1:0] tl_q,
    output logic [CNT_W-1:0] th_q,
    output logic             tick_q,
    output logic             flag_q
);
    tmr_mode_e          mode_e;
    logic [CNT_W-1:0]   tl_d;
    logic [CNT_W-1:0]   th_d;
    logic [2*CNT_W-1:0] wide_inc;
    logic               wrap;

    assign mode_e   = tmr_mode_e'(mode);
    assign wide_inc = {th_q, tl_q} + 1'b1;

    always_comb begin
        tl_d = tl_q;
        th_d = th_q;
        wrap = 1'b0;
        if (inc) begin
            unique case (mode_e)
                MODE_SPLIT13: begin
                    if (&tl_q[PRESC_W-1:0]) begin
                        tl_d[PRESC_W-1:0] = '0;
                        th_d = th_q + 1'b1;
                        wrap = &th_q;
                    end else begin
                        tl_d[PRESC_W-1:0] = tl_q[PRESC_W-1:0] + 1'b1;
                    end
                end
                MODE_WIDE16: begin
                    {th_d, tl_d} = wide_inc;
                    wrap = &{th_q, tl_q};
                end
                MODE_RELOAD8: begin
                    if (&tl_q) begin
                        tl_d = th_q;
                        wrap = 1'b1;
                    end else begin
                        tl_d = tl_q + 1'b1;
                    end
                end
                MODE_HALT: begin
                    tl_d = tl_q;
                end
            endcase
        end
        if (wr_lo)
            tl_d = wr_data;
        if (wr_hi)
            th_d = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tl_q   <= '0;
            th_q   <= '0;
            tick_q <= 1'b0;
            flag_q <= 1'b0;
        end else begin
            tl_q   <= tl_d;
            th_q   <= th_d;
            tick_q <= wrap;
            if (wrap)
                flag_q <= 1'b1;
            else if (flag_clr)
                flag_q <= 1'b0;
        end
    end
endmodule

// File: rtl/autoreload_timer.sv
module autoreload_timer #(
    parameter int CNT_W       = 8,
    parameter int PRESC_W     = 5,
    parameter int SLOW_DIV    = 12,
    parameter int MID_DIV     = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             gate_en,
    input  logic             ext_count_sel,
    input  logic             fast_clk_sel,
    input  logic             div4_sel,
    input  logic [1:0]       mode,
    input  logic             gate_pin,
    input  logic             count_pin,
    input  logic             wr_lo,
    input  logic             wr_hi,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             flag_clr,
    input  logic             irq_en,
    output logic [CNT_W-1:0] count_lo,
    output logic [CNT_W-1:0] count_hi,
    output logic             ovf_flag,
    output logic             ovf_tick,
    output logic             irq
);
    logic pre_tick;
    logic gate_sync;
    logic fall_pulse;
    logic src_tick;
    logic count_ok;
    logic inc;

    tmr_prescaler #(
        .SLOW_DIV (SLOW_DIV),
        .MID_DIV  (MID_DIV)
    ) u_presc (
        .clk      (clk),
        .rst_n    (rst_n),
        .fast_sel (fast_clk_sel),
        .mid_sel  (div4_sel),
        .tick     (pre_tick)
    );

    tmr_pin_sync #(
        .STAGES (SYNC_STAGES)
    ) u_pins (
        .clk        (clk),
        .rst_n      (rst_n),
        .gate_raw   (gate_pin),
        .count_raw  (count_pin),
        .gate_sync  (gate_sync),
        .fall_pulse (fall_pulse)
    );

    assign src_tick = ext_count_sel ? fall_pulse : pre_tick;
    assign count_ok = run && (!gate_en || gate_sync);
    assign inc      = count_ok && src_tick && !wr_lo && !wr_hi;

    tmr_core #(
        .CNT_W   (CNT_W),
        .PRESC_W (PRESC_W)
    ) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .inc      (inc),
        .mode     (mode),
        .wr_lo    (wr_lo),
        .wr_hi    (wr_hi),
        .wr_data  (wr_data),
        .flag_clr (flag_clr),
        .tl_q     (count_lo),
        .th_q     (count_hi),
        .tick_q   (ovf_tick),
        .flag_q   (ovf_flag)
    );

    assign irq = ovf_flag & irq_en;
endmodule

// File: rtl/autoreload_timer_chk.sv
module autoreload_timer_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run,
    input logic [1:0]       mode,
    input logic             wr_lo,
    input logic             wr_hi,
    input logic             flag_clr,
    input logic [CNT_W-1:0] count_lo,
    input logic [CNT_W-1:0] count_hi,
    input logic             ovf_flag,
    input logic             ovf_tick,
    input logic             irq
);
    AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b11 && !wr_lo && !wr_hi) |=> ($stable(count_lo) && $stable(count_hi))); // R8

    AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !wr_lo && !wr_hi) |=> ($stable(count_lo) && $stable(count_hi))); // R3

    AST_TICK_WITH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_tick |-> ovf_flag); // R9

    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ovf_flag); // R9

    AST_RELOAD_FROM_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_tick && $past(mode) == 2'b10) |-> (count_lo == count_hi)); // R7

    AST_CLEAR_WINS_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        flag_clr |=> (ovf_tick || !ovf_flag)); // R10
endmodule

bind autoreload_timer autoreload_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .mode     (mode),
    .wr_lo    (wr_lo),
    .wr_hi    (wr_hi),
    .flag_clr (flag_clr),
    .count_lo (count_lo),
    .count_hi (count_hi),
    .ovf_flag (ovf_flag),
    .ovf_tick (ovf_tick),
    .irq      (irq)
);

// File: tb/autoreload_timer_tb.sv
module autoreload_timer_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       run = 1'b0, gate_en = 1'b0, ext_count_sel = 1'b0;
    logic       fast_clk_sel = 1'b0, div4_sel = 1'b0;
    logic [1:0] mode = 2'b01;
    logic       gate_pin = 1'b0, count_pin = 1'b0;
    logic       wr_lo = 1'b0, wr_hi = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       flag_clr = 1'b0, irq_en = 1'b0;
    logic [7:0] count_lo, count_hi;
    logic       ovf_flag, ovf_tick, irq;

    int    n_checks = 0;
    int    n_fails  = 0;
    bit    cmp_on   = 1'b0;
    bit    done     = 1'b0;
    string cur_req  = "R1";

    // reference model state
    int m_pre, m_tl, m_th, m_v, m_div;
    bit m_s1, m_s2, m_hi, m_g1, m_g2, m_flag, m_tick;
    bit m_ptick, m_fall, m_en, m_inc, m_wrap;

    always #2 clk = ~clk;

    autoreload_timer u_dut (
        .clk(clk), .rst_n(rst_n), .run(run), .gate_en(gate_en),
        .ext_count_sel(ext_count_sel), .fast_clk_sel(fast_clk_sel),
        .div4_sel(div4_sel), .mode(mode), .gate_pin(gate_pin),
        .count_pin(count_pin), .wr_lo(wr_lo), .wr_hi(wr_hi),
        .wr_data(wr_data), .flag_clr(flag_clr), .irq_en(irq_en),
        .count_lo(count_lo), .count_hi(count_hi), .ovf_flag(ovf_flag),
        .ovf_tick(ovf_tick), .irq(irq)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pre = 0; m_tl = 0; m_th = 0;
            m_s1 = 0; m_s2 = 0; m_hi = 0; m_g1 = 0; m_g2 = 0;
            m_flag = 0; m_tick = 0;
        end else begin
            m_div   = fast_clk_sel ? 1 : (div4_sel ? 4 : 12);
            m_ptick = (m_pre >= m_div - 1);
            m_fall  = m_hi && !m_s2;
            m_en    = run && (!gate_en || m_g2);
            m_inc   = m_en && (ext_count_sel ? m_fall : m_ptick) && !wr_lo && !wr_hi;
            m_wrap  = 0;
            if (m_inc) begin
                case (mode)
                    2'b00: begin
                        m_v = m_th * 32 + (m_tl % 32) + 1;
                        m_wrap = (m_v == 8192);
                        m_v = m_v % 8192;
                        m_th = m_v / 32;
                        m_tl = (m_tl / 32) * 32 + (m_v % 32);
                    end
                    2'b01: begin
                        m_v = m_th * 256 + m_tl + 1;
                        m_wrap = (m_v == 65536);
                        m_v = m_v % 65536;
                        m_th = m_v / 256;
                        m_tl = m_v % 256;
                    end
                    2'b10: begin
                        if (m_tl == 255) begin m_tl = m_th; m_wrap = 1; end
                        else m_tl = m_tl + 1;
                    end
                    default: ;
                endcase
            end
            if (wr_lo) m_tl = wr_data;
            if (wr_hi) m_th = wr_data;
            m_tick = m_wrap;
            if (m_wrap) m_flag = 1;
            else if (flag_clr) m_flag = 0;
            m_pre = m_ptick ? 0 : m_pre + 1;
            m_hi = m_s2; m_s2 = m_s1; m_s1 = count_pin;
            m_g2 = m_g1; m_g1 = gate_pin;
        end
    end

    // compare every clock, away from the active edge
    always @(negedge clk) begin
        if (cmp_on && !done) begin
            n_checks++;
            if (count_lo !== 8'(m_tl) || count_hi !== 8'(m_th) || ovf_flag !== m_flag ||
                ovf_tick !== m_tick || irq !== (m_flag && irq_en)) begin
                n_fails++;
                $display("FAIL %s t=%0t lo/hi/flag/tick/irq got %h %h %b %b %b exp %h %h %b %b %b",
                         cur_req, $time, count_lo, count_hi, ovf_flag, ovf_tick, irq,
                         8'(m_tl), 8'(m_th), m_flag, m_tick, m_flag && irq_en);
            end
        end
    end

    task automatic step(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check(string req, logic [7:0] got, logic [7:0] exp);
        @(negedge clk);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s got %h expected %h", req, got, exp);
        end
        @(posedge clk); #1;
    endtask

    task automatic write(bit lo, bit hi, logic [7:0] d);
        wr_lo = lo; wr_hi = hi; wr_data = d;
        step(1);
        wr_lo = 0; wr_hi = 0;
    endtask

    task automatic summary();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        step(3);
        #1;
        // R1: reset values
        check("R1", count_lo, 8'h00);
        check("R1", count_hi, 8'h00);
        check("R1", {5'b0, ovf_flag, ovf_tick, irq}, 8'h00);
        rst_n = 1'b1;
        step(1);
        cmp_on = 1'b1;

        // R2: prescale rates, 16-bit mode
        cur_req = "R2"; mode = 2'b01; run = 1;
        fast_clk_sel = 1; div4_sel = 0; step(40);
        div4_sel = 1; step(20);
        fast_clk_sel = 0; step(60);
        div4_sel = 0; step(100);

        // R6 and R9: 16-bit wrap with interrupt enabled
        cur_req = "R6"; fast_clk_sel = 1; irq_en = 1;
        write(1, 1, 8'hFF); write(1, 0, 8'hF0); step(30);
        cur_req = "R9"; irq_en = 0; step(3); irq_en = 1; step(3);

        // R10: clear flag
        cur_req = "R10"; flag_clr = 1; step(1); flag_clr = 0; step(5);
        write(1, 1, 8'hFF); flag_clr = 1; step(20); flag_clr = 0; step(3);

        // R7: reload mode
        cur_req = "R7"; mode = 2'b10; write(1, 1, 8'hFD); step(40);
        fast_clk_sel = 0; div4_sel = 1; step(100);
        fast_clk_sel = 1; write(0, 1, 8'hFF); step(10);

        // R5: split 13-bit mode
        cur_req = "R5"; mode = 2'b00; write(0, 1, 8'hFF); write(1, 0, 8'hFC);
        step(40);
        check("R5", count_lo[7:5], 3'b111);

        // R8: halt
        cur_req = "R8"; mode = 2'b11; step(30);

        // R11: write during halt and while counting
        cur_req = "R11"; write(1, 0, 8'h5A);
        check("R11", count_lo, 8'h5A);
        mode = 2'b01; step(5); write(1, 0, 8'h20); step(5); write(0, 1, 8'h33); step(5);

        // R3: run and gate
        cur_req = "R3"; run = 0; step(10); run = 1; gate_en = 1; gate_pin = 0; step(10);
        gate_pin = 1; step(10); gate_pin = 0; step(7); gate_pin = 1; step(3);
        run = 0; step(5); gate_en = 0; run = 1; step(5);

        // R4: external count pin edges
        cur_req = "R4"; ext_count_sel = 1; count_pin = 0; write(1, 1, 8'h00); write(1, 0, 8'h10);
        for (int i = 0; i < 3; i++) begin
            count_pin = 1; step(4); count_pin = 0; step(4);
        end
        step(4);
        check("R4", count_lo, 8'h13);
        check("R4", count_hi, 8'h00);
        ext_count_sel = 0; step(10);

        cmp_on = 1'b0;
        summary();
    end
endmodule